// File: doc/BRIEF.md
# Bus Cycle Breakpoint Comparator

This block watches every processor bus cycle and decides whether it should cause a debug breakpoint. A cycle qualifies when its 24-bit address agrees with a programmed address under a per-bit don't-care mask, and its two control attributes also agree with programmed values. The two attributes are the transfer direction (read or write) and the cycle kind (instruction fetch or data). Each attribute has its own compare bit and its own mask bit.

A small register port sets the operating mode and the compare and mask values. In single mode the block drives a registered breakpoint pin. In multiple mode that pin is an input from other matchers, and it is ANDed into the internal match. In program mode the control-attribute registers take no part in the match. A sticky hit flag records that a qualifying cycle happened. Software clears it by writing 1 to it.

Top module: `bus_bkpt_cmp`

## Requirements
- R1: After reset every register reads 0, the mode is disabled (00), and `brk_out` and `brk_oe` are both 0.
- R2: Register word addresses are 0 = configuration (mode in bits 1:0, hit flag in bit 8), 1 = address compare, 2 = address mask, 3 = control compare, 4 = control mask. In both control registers only bits 1:0 can be written. Bits 15:2 always read 0.
- R3: An address bit takes part in the match only when its address-mask bit is 0. A mask bit of 1 makes that address bit don't-care.
- R4: Control compare bit 1 selects the direction: 1 matches only read cycles (`cyc_read`=1), 0 matches only write cycles.
- R5: Control compare bit 0 selects the cycle kind: 1 matches only instruction fetches (`cyc_instr`=1), 0 matches only data cycles.
- R6: A control mask bit of 1 (bit 1 for direction, bit 0 for kind) makes that attribute match whatever its value.
- R7: In single mode (01), a qualifying cycle makes `brk_out` go to 1 on the clock edge that samples the cycle, for exactly one cycle. `brk_oe` is 1 only while the mode is single.
- R8: In multiple mode (10), a cycle qualifies only when `brk_in` is 1 as well. `brk_oe` and `brk_out` stay 0.
- R9: In program mode (11), the control compare and mask registers are ignored, so only the address decides the match.
- R10: A cycle with `cyc_valid` low never qualifies.
- R11: The hit flag is set on the edge that samples a qualifying cycle in any enabled mode. It then holds until a write to word 0 with bit 8 set clears it. A qualifying cycle in the same clock as the clear wins, and the flag stays set.
- R12: In the disabled mode (00), no cycle qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |
| cyc_valid | input | 1 | Bus cycle valid strobe |
| cyc_addr | input | 24 | Bus cycle address |
| cyc_read | input | 1 | 1 = read cycle, 0 = write cycle |
| cyc_instr | input | 1 | 1 = instruction fetch, 0 = data cycle |
| brk_in | input | 1 | Breakpoint pin as seen from the pad (used in multiple mode) |
| brk_out | output | 1 | Registered breakpoint pin drive |
| brk_oe | output | 1 | Drive enable for the breakpoint pin |

## Verification
Address patterns are tried that differ from the compare value only in masked bits, and others that differ only in unmasked bits. Together they show that the mask is applied bit by bit. Each control attribute is flipped on its own while the other is held matching. Each attribute is then unmasked and masked in turn. This separates the direction compare, the kind compare and their masks from each other. The same set of cycles is repeated in every mode, with `brk_in` toggled, to show how the pin combines with the match and that the control registers are ignored in program mode. The clear of the hit flag is also issued in the same clock as a qualifying cycle.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_MULTI  = 2'b10,
    MODE_PROG   = 2'b11
  } bkpt_mode_e;

  localparam int REG_CFG  = 0;
  localparam int REG_ACMP = 1;
  localparam int REG_AMSK = 2;
  localparam int REG_CCMP = 3;
  localparam int REG_CMSK = 4;

  localparam int HIT_BIT  = 8;
  localparam int CTL_W    = 2;
  localparam int CTL_DIR  = 1;
  localparam int CTL_KIND = 0;

  // One address bit agrees when it is masked out or equal to the compare bit.
  function automatic logic addr_bit_ok(logic a, logic c, logic m);
    return m | ~(a ^ c);
  endfunction

  // One control attribute agrees when masked or equal to its compare value.
  function automatic logic ctl_attr_ok(logic val, logic cmp, logic msk);
    return msk | (val == cmp);
  endfunction

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int RAW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [RAW-1:0]    addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hit_set,
  output bkpt_mode_e        mode,
  output logic [ADDR_W-1:0] acmp,
  output logic [ADDR_W-1:0] amsk,
  output logic [CTL_W-1:0]  ccmp,
  output logic [CTL_W-1:0]  cmsk,
  output logic              hit_q,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_A = DATA_W - ADDR_W;
  localparam int PAD_C = DATA_W - CTL_W;

  logic wr_cfg, wr_acmp, wr_amsk, wr_ccmp, wr_cmsk;
  logic hit_clr;
  logic unused_wdata_hi;

  assign wr_cfg  = wr && (addr == RAW'(REG_CFG));
  assign wr_acmp = wr && (addr == RAW'(REG_ACMP));
  assign wr_amsk = wr && (addr == RAW'(REG_AMSK));
  assign wr_ccmp = wr && (addr == RAW'(REG_CCMP));
  assign wr_cmsk = wr && (addr == RAW'(REG_CMSK));
  assign hit_clr = wr_cfg && wdata[HIT_BIT];
  assign unused_wdata_hi = ^wdata[DATA_W-1:ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_OFF;
      acmp <= '0;
      amsk <= '0;
      ccmp <= '0;
      cmsk <= '0;
    end else begin
      if (wr_cfg)  mode <= bkpt_mode_e'(wdata[1:0]);
      if (wr_acmp) acmp <= wdata[ADDR_W-1:0];
      if (wr_amsk) amsk <= wdata[ADDR_W-1:0];
      if (wr_ccmp) ccmp <= wdata[CTL_W-1:0];
      if (wr_cmsk) cmsk <= wdata[CTL_W-1:0];
    end
  end

  // Set wins over clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hit_q <= 1'b0;
    else if (hit_set) hit_q <= 1'b1;
    else if (hit_clr) hit_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RAW'(REG_CFG): begin
        rdata[1:0]     = mode;
        rdata[HIT_BIT] = hit_q;
      end
      RAW'(REG_ACMP): rdata = {{PAD_A{1'b0}}, acmp};
      RAW'(REG_AMSK): rdata = {{PAD_A{1'b0}}, amsk};
      RAW'(REG_CCMP): rdata = {{PAD_C{1'b0}}, ccmp};
      RAW'(REG_CMSK): rdata = {{PAD_C{1'b0}}, cmsk};
      default:        rdata = '0;
    endcase
  end

endmodule

// File: rtl/bkpt_addr_cmp.sv
module bkpt_addr_cmp
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [ADDR_W-1:0] acmp,
  input  logic [ADDR_W-1:0] amsk,
  output logic              match
);

  logic [ADDR_W-1:0] bit_ok;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign bit_ok[i] = addr_bit_ok(cyc_addr[i], acmp[i], amsk[i]);
  end

  assign match = &bit_ok;

endmodule

// File: rtl/bkpt_ctrl_cmp.sv
module bkpt_ctrl_cmp
  import bkpt_pkg::*;
(
  input  logic             cyc_read,
  input  logic             cyc_instr,
  input  logic [CTL_W-1:0] ccmp,
  input  logic [CTL_W-1:0] cmsk,
  output logic             match
);

  logic [CTL_W-1:0] attr;
  logic [CTL_W-1:0] attr_ok;

  always_comb begin
    attr           = '0;
    attr[CTL_DIR]  = cyc_read;
    attr[CTL_KIND] = cyc_instr;
  end

  for (genvar i = 0; i < CTL_W; i++) begin : g_attr
    assign attr_ok[i] = ctl_attr_ok(attr[i], ccmp[i], cmsk[i]);
  end

  assign match = &attr_ok;

endmodule

// File: rtl/bus_bkpt_cmp.sv
module bus_bkpt_cmp
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int RAW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [RAW-1:0]    cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              cyc_valid,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              cyc_read,
  input  logic              cyc_instr,
  input  logic              brk_in,
  output logic              brk_out,
  output logic              brk_oe
);

  bkpt_mode_e        mode;
  logic [ADDR_W-1:0] acmp, amsk;
  logic [CTL_W-1:0]  ccmp, cmsk;
  logic              hit_q;
  logic              addr_hit, ctl_hit;
  logic              qual;
  logic              brk_q;

  bkpt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .hit_set(qual), .mode(mode), .acmp(acmp),
    .amsk(amsk), .ccmp(ccmp), .cmsk(cmsk), .hit_q(hit_q), .rdata(cfg_rdata)
  );

  bkpt_addr_cmp #(.ADDR_W(ADDR_W)) u_addr (
    .cyc_addr(cyc_addr), .acmp(acmp), .amsk(amsk), .match(addr_hit)
  );

  bkpt_ctrl_cmp u_ctrl (
    .cyc_read(cyc_read), .cyc_instr(cyc_instr), .ccmp(ccmp),
    .cmsk(cmsk), .match(ctl_hit)
  );

  always_comb begin
    case (mode)
      MODE_SINGLE: qual = cyc_valid & addr_hit & ctl_hit;
      MODE_MULTI:  qual = cyc_valid & addr_hit & ctl_hit & brk_in;
      MODE_PROG:   qual = cyc_valid & addr_hit;
      default:     qual = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_q <= 1'b0;
    else        brk_q <= qual && (mode == MODE_SINGLE);
  end

  assign brk_out = brk_q;
  assign brk_oe  = (mode == MODE_SINGLE);

endmodule

// File: rtl/bus_bkpt_cmp_chk.sv
module bus_bkpt_cmp_chk
  import bkpt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RAW    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [RAW-1:0]    cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              cyc_valid,
  input logic              brk_in,
  input logic              brk_out,
  input logic              brk_oe,
  input bkpt_mode_e        mode,
  input logic              qual,
  input logic              hit_q
);

  assert_ctl_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == RAW'(REG_CCMP) || cfg_addr == RAW'(REG_CMSK)) |-> cfg_rdata[15:2] == '0);

  assert_pin_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_out |-> brk_oe);

  assert_single_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && mode == MODE_SINGLE) |=> brk_out);

  assert_multi_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && mode == MODE_MULTI) |-> brk_in);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> !qual);

  assert_hit_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> hit_q);

  assert_hit_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !(cfg_wr && cfg_addr == RAW'(REG_CFG) && cfg_wdata[HIT_BIT])) |=> hit_q);

  assert_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |-> !qual);

endmodule

bind bus_bkpt_cmp bus_bkpt_cmp_chk #(.DATA_W(DATA_W), .RAW(RAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cyc_valid(cyc_valid),
  .brk_in(brk_in), .brk_out(brk_out), .brk_oe(brk_oe), .mode(mode),
  .qual(qual), .hit_q(hit_q)
);

// File: tb/bus_bkpt_cmp_bench.sv
module bus_bkpt_cmp_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cyc_valid = 1'b0;
  logic [23:0] cyc_addr = '0;
  logic        cyc_read = 1'b0;
  logic        cyc_instr = 1'b0;
  logic        brk_in = 1'b0;
  logic        brk_out, brk_oe;

  int errors = 0;
  int checks = 0;

  // reference model state
  int          m_mode = 0;
  logic [23:0] m_acmp = '0, m_amsk = '0;
  logic [1:0]  m_ccmp = '0, m_cmsk = '0;
  bit          m_hit = 0, m_brk = 0;

  always #5 clk = ~clk;

  bus_bkpt_cmp u_bus_bkpt_cmp (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit model_qual();
    bit a_ok = 1, c_ok = 1;
    if (!cyc_valid) return 0;
    for (int i = 0; i < 24; i++)
      if (!m_amsk[i] && cyc_addr[i] != m_acmp[i]) a_ok = 0;
    if (!m_cmsk[1] && (cyc_read != m_ccmp[1])) c_ok = 0;
    if (!m_cmsk[0] && (cyc_instr != m_ccmp[0])) c_ok = 0;
    case (m_mode)
      1: return a_ok && c_ok;
      2: return a_ok && c_ok && brk_in;
      3: return a_ok;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] model_read(int a);
    case (a)
      0: return {23'd0, m_hit, 6'd0, 2'(m_mode)};
      1: return {8'd0, m_acmp};
      2: return {8'd0, m_amsk};
      3: return {30'd0, m_ccmp};
      4: return {30'd0, m_cmsk};
      default: return 32'd0;
    endcase
  endfunction

  // one clock; model advances with the inputs held across the edge
  task automatic tick();
    bit q;
    @(posedge clk);
    #1;
    q = model_qual();
    m_brk = q && (m_mode == 1);
    if (q) m_hit = 1;
    else if (cfg_wr && cfg_addr == 0 && cfg_wdata[8]) m_hit = 0;
    if (cfg_wr) begin
      case (cfg_addr)
        3'd0: m_mode = int'(cfg_wdata[1:0]);
        3'd1: m_acmp = cfg_wdata[23:0];
        3'd2: m_amsk = cfg_wdata[23:0];
        3'd3: m_ccmp = cfg_wdata[1:0];
        3'd4: m_cmsk = cfg_wdata[1:0];
        default: ;
      endcase
    end
    check("R7 R8 brk_out", 32'(brk_out), 32'(m_brk));
    check("R7 R8 brk_oe", 32'(brk_oe), 32'(m_mode == 1));
    cfg_wr = 0;
    cyc_valid = 0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    cfg_wr = 1; cfg_addr = 3'(a); cfg_wdata = d;
    tick();
  endtask

  task automatic rd(string req, int a);
    cfg_addr = 3'(a);
    #1;
    check(req, cfg_rdata, model_read(a));
  endtask

  task automatic cyc(logic [23:0] ad, bit r, bit ins, bit pin);
    cyc_valid = 1; cyc_addr = ad; cyc_read = r; cyc_instr = ins; brk_in = pin;
    tick();
    brk_in = 0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      cfg_addr = 3'(a); #1;
      check("R1 reg", cfg_rdata, 32'd0);
    end
    check("R1 brk_out", 32'(brk_out), 0);
    check("R1 brk_oe", 32'(brk_oe), 0);
    tick();
    // R2 reserved control bits
    wr(3, 32'hFFFF_FFFF); rd("R2 ccmp", 3);
    check("R2 ccmp value", cfg_rdata, 32'd3);
    wr(4, 32'hFFFF_FFFF); rd("R2 cmsk", 4);
    check("R2 cmsk value", cfg_rdata, 32'd3);
    wr(4, 0);
    wr(1, 32'hAB12_3450); rd("R2 acmp", 1);
    wr(2, 32'h0000_000F);
    wr(0, 1);
    rd("R7 mode single", 0);
    // R3 address masking
    cyc(24'h123457, 1, 1, 0);
    check("R3 R7 masked bits differ -> brk", 32'(brk_out), 1);
    tick();
    check("R7 brk one cycle", 32'(brk_out), 0);
    cyc(24'h123467, 1, 1, 0);
    check("R3 unmasked bit differs", 32'(brk_out), 0);
    // R4 direction, R5 kind
    cyc(24'h123450, 0, 1, 0);
    check("R4 write vs read compare", 32'(brk_out), 0);
    cyc(24'h123450, 1, 0, 0);
    check("R5 data vs instr compare", 32'(brk_out), 0);
    wr(3, 32'h0);
    cyc(24'h123450, 0, 0, 0);
    check("R4 R5 write data matches", 32'(brk_out), 1);
    // R6 masks
    wr(4, 32'h2);
    cyc(24'h123450, 1, 0, 0);
    check("R6 dir masked", 32'(brk_out), 1);
    cyc(24'h123450, 1, 1, 0);
    check("R6 kind unmasked", 32'(brk_out), 0);
    wr(4, 32'h3);
    cyc(24'h123450, 1, 1, 0);
    check("R6 both masked", 32'(brk_out), 1);
    // R10 invalid cycle
    wr(0, 32'h101); rd("R11 cleared", 0);
    cyc_addr = 24'h123450; tick();
    check("R10 idle no brk", 32'(brk_out), 0);
    rd("R10 idle no hit", 0);
    // R11 set wins over clear
    cyc_valid = 1; cyc_addr = 24'h123450;
    cfg_wr = 1; cfg_addr = 0; cfg_wdata = 32'h101;
    tick();
    rd("R11 set beats clear", 0);
    check("R11 hit bit", cfg_rdata[8], 1);
    // R8 multiple mode
    wr(0, 32'h102);
    cyc(24'h123450, 0, 0, 0);
    rd("R8 pin low no hit", 0);
    check("R8 hit stays 0", cfg_rdata[8], 0);
    cyc(24'h123450, 0, 0, 1);
    check("R8 no drive", 32'(brk_out), 0);
    rd("R8 pin high hit", 0);
    check("R8 hit 1", cfg_rdata[8], 1);
    // R9 program mode ignores control regs
    wr(4, 0); wr(3, 32'h3);
    wr(0, 32'h103);
    cyc(24'h123450, 0, 0, 0);
    rd("R9 ctl ignored", 0);
    check("R9 hit", cfg_rdata[8], 1);
    cyc(24'h023450, 0, 0, 0);
    wr(0, 32'h103);
    cyc(24'h023450, 1, 1, 0);
    rd("R9 addr still checked", 0);
    // R12 disabled
    wr(0, 32'h100);
    cyc(24'h123450, 1, 1, 1);
    rd("R12 off no hit", 0);
    check("R12 hit 0", cfg_rdata[8], 0);
    tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule